// File: doc/BRIEF.md
# Triple lockstep voter and resynchronizer

This block stands between three identical processor cores that execute the same program in lockstep and the memory and I/O that they share. Every cycle it takes the three core output buses and forms a bit-by-bit majority, and only that voted bus is passed on. A single misbehaving core therefore cannot corrupt anything outside the core cluster.

In the same cycle, the block compares the three buses. If one core disagrees with the other two, it records a correctable error together with the index of that core, and the system keeps running on the two cores that agree. If all three cores disagree with each other, it records an uncorrectable error. While a correctable error is pending, the recorded core is left out of the comparison, and any split between the two remaining cores is uncorrectable.

When software decides the time is right, it pulses a start input, and the hardware then resynchronizes the cores. It stalls all three cores and collects every architectural state word from each of them. It then writes the voted value of each word back into all three cores, and releases the stall. A cycle budget bounds the whole sequence, and a failure flag reports an overrun.

Top module: `tmr_lockstep_guard`

## Requirements
- R1: `voted_out` is the bitwise majority of `lane_a`, `lane_b` and `lane_c` in the same cycle, with no register on the path.
- R2: When exactly one lane differs and the other two are equal, `err_corr` is 1 from the next cycle on. `fault_id` then gives that lane: 0 for a, 1 for b, 2 for c. When no correctable error is recorded, `fault_id` reads 3.
- R3: When all three lanes differ pairwise, `err_uncorr` is 1 from the next cycle on.
- R4: While `err_corr` is set, the recorded lane is ignored and `fault_id` does not change. If the two other lanes differ, `err_uncorr` is set.
- R5: The error flags and `fault_id` hold their values until `err_clear` is high at a clock edge or a resync completes. `err_clear` has priority over a detection in the same cycle and also clears `resync_fail`.
- R6: A `resync_start` pulse in idle raises `core_hold` in the next cycle. During the push phase `state_idx` steps from 0 to STATE_WORDS-1, and it advances only on a cycle in which all three bits of `st_out_vld` are 1 (bit k is core k). A start pulse that arrives while `core_hold` is high has no effect.
- R7: After the push phase comes the restore phase. It asserts `st_in_we` for STATE_WORDS consecutive cycles, with `state_idx` at 0 up to STATE_WORDS-1, and on each cycle `st_in_data` carries the bitwise majority of the three words pushed for that index. `core_hold` falls in the cycle after the last write. If the valid bits are never low, `core_hold` is high for exactly 2*STATE_WORDS cycles.
- R8: When a resync completes, `err_corr`, `err_uncorr` and `resync_fail` are cleared and `fault_id` returns to 3.
- R9: If a resync is not complete after BUDGET cycles with `core_hold` high, it is abandoned: `core_hold` falls after exactly BUDGET cycles, `resync_fail` is set and stays set, and the error flags keep their values.
- R10: While `core_hold` is high, lane disagreement does not set any error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_a | input | BUS_W | Output bus of core 0 |
| lane_b | input | BUS_W | Output bus of core 1 |
| lane_c | input | BUS_W | Output bus of core 2 |
| voted_out | output | BUS_W | Majority-voted bus to memory and I/O |
| err_corr | output | 1 | Sticky flag: single-lane mismatch seen |
| err_uncorr | output | 1 | Sticky flag: mismatch that voting cannot resolve |
| fault_id | output | 2 | Index of the disagreeing core, 3 when none |
| err_clear | input | 1 | Clears error flags and resync failure |
| resync_start | input | 1 | Pulse that starts a resync |
| core_hold | output | 1 | Stalls all three cores during resync |
| state_idx | output | $clog2(STATE_WORDS) | State word index for push and restore |
| st_out_a | input | STATE_W | State word pushed by core 0 |
| st_out_b | input | STATE_W | State word pushed by core 1 |
| st_out_c | input | STATE_W | State word pushed by core 2 |
| st_out_vld | input | 3 | Per-core push valid, bit k for core k |
| st_in_data | output | STATE_W | Voted state word written into all cores |
| st_in_we | output | 1 | Write strobe for the restored word |
| resync_fail | output | 1 | Sticky flag: resync overran the budget |

## Verification
The bench builds the block with 8-bit buses, 8-bit state words, six state words and a budget of 20 cycles. With six words, a stall-free resync takes only twelve cycles, and single-core words, all-split words and push stalls can each be placed on chosen indices. With a budget of 20, an overrun can be forced in a few cycles by holding one valid bit low, and the exact abort point then falls inside a short run. The narrow buses make the random patterns produce frequent single-lane and three-way mismatches, on top of the equal-lane cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_PUSH    = 2'd1,
        SEQ_RESTORE = 2'd2
    } seq_st_e;

    localparam logic [1:0] NO_FAULT = 2'd3;

    typedef struct packed {
        logic       corr;
        logic       uncorr;
        logic [1:0] fid;
    } flag_t;

endpackage

// File: rtl/tmr_maj.sv
module tmr_maj #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] y
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
    end
endmodule

// File: rtl/tmr_classify.sv
module tmr_classify #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic         en,
    input  logic         pend,
    input  logic [1:0]   pend_id,
    output logic         corr_hit,
    output logic         uncorr_hit,
    output logic [1:0]   odd_id
);
    logic eq_ab, eq_ac, eq_bc;
    logic rest_eq;

    assign eq_ab = (a == b);
    assign eq_ac = (a == c);
    assign eq_bc = (b == c);

    always_comb begin
        case (pend_id)
            2'd0:    rest_eq = eq_bc;
            2'd1:    rest_eq = eq_ac;
            default: rest_eq = eq_ab;
        endcase
    end

    always_comb begin
        corr_hit   = 1'b0;
        uncorr_hit = 1'b0;
        odd_id     = tmr_pkg::NO_FAULT;
        if (en) begin
            if (pend) begin
                uncorr_hit = !rest_eq;
            end else if (eq_ab && eq_bc) begin
                corr_hit = 1'b0;
            end else if (eq_bc) begin
                corr_hit = 1'b1;
                odd_id   = 2'd0;
            end else if (eq_ac) begin
                corr_hit = 1'b1;
                odd_id   = 2'd1;
            end else if (eq_ab) begin
                corr_hit = 1'b1;
                odd_id   = 2'd2;
            end else begin
                uncorr_hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_resync_seq.sv
module tmr_resync_seq
    import tmr_pkg::*;
#(
    parameter int STATE_W = 32,
    parameter int WORDS   = 64,
    parameter int BUDGET  = 2500
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     clear,
    input  logic [STATE_W-1:0]       st_a,
    input  logic [STATE_W-1:0]       st_b,
    input  logic [STATE_W-1:0]       st_c,
    input  logic [2:0]               st_vld,
    output logic                     busy,
    output logic [$clog2(WORDS)-1:0] idx,
    output logic                     wr_en,
    output logic [STATE_W-1:0]       wr_data,
    output logic                     done_ok,
    output logic                     fail
);
    localparam int IDX_W = $clog2(WORDS);
    localparam int TMR_W = $clog2(BUDGET + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);
    localparam logic [TMR_W-1:0] LAST_TMR = TMR_W'(BUDGET - 1);

    typedef struct packed {
        seq_st_e          st;
        logic [IDX_W-1:0] idx;
        logic [TMR_W-1:0] tmr;
        logic             fail;
    } seq_t;

    seq_t seq_d, seq_q;
    logic               cap;
    logic [STATE_W-1:0] st_vote;
    logic [STATE_W-1:0] word_q [WORDS];

    tmr_maj #(.W(STATE_W)) u_state_vote (
        .a (st_a),
        .b (st_b),
        .c (st_c),
        .y (st_vote)
    );

    always_comb begin
        seq_d   = seq_q;
        cap     = 1'b0;
        done_ok = 1'b0;
        if (clear) begin
            seq_d.fail = 1'b0;
        end
        case (seq_q.st)
            SEQ_IDLE: begin
                if (start) begin
                    seq_d.st  = SEQ_PUSH;
                    seq_d.idx = '0;
                    seq_d.tmr = '0;
                end
            end
            SEQ_PUSH: begin
                seq_d.tmr = seq_q.tmr + 1'b1;
                if (&st_vld) begin
                    cap = 1'b1;
                    if (seq_q.idx == LAST_IDX) begin
                        seq_d.st  = SEQ_RESTORE;
                        seq_d.idx = '0;
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                    end
                end
            end
            SEQ_RESTORE: begin
                seq_d.tmr = seq_q.tmr + 1'b1;
                if (seq_q.idx == LAST_IDX) begin
                    seq_d.st   = SEQ_IDLE;
                    seq_d.fail = 1'b0;
                    done_ok    = 1'b1;
                end else begin
                    seq_d.idx = seq_q.idx + 1'b1;
                end
            end
            default: seq_d.st = SEQ_IDLE;
        endcase
        if ((seq_q.st != SEQ_IDLE) && !done_ok && (seq_q.tmr == LAST_TMR)) begin
            seq_d.st   = SEQ_IDLE;
            seq_d.fail = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SEQ_IDLE, idx: '0, tmr: '0, fail: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    always_ff @(posedge clk) begin
        if (cap) begin
            word_q[seq_q.idx] <= st_vote;
        end
    end

    assign busy    = (seq_q.st != SEQ_IDLE);
    assign idx     = seq_q.idx;
    assign wr_en   = (seq_q.st == SEQ_RESTORE);
    assign wr_data = word_q[seq_q.idx];
    assign fail    = seq_q.fail;
endmodule

// File: rtl/tmr_lockstep_guard.sv
module tmr_lockstep_guard
    import tmr_pkg::*;
#(
    parameter int BUS_W       = 32,
    parameter int STATE_W     = 32,
    parameter int STATE_WORDS = 64,
    parameter int BUDGET      = 2500
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [BUS_W-1:0]               lane_a,
    input  logic [BUS_W-1:0]               lane_b,
    input  logic [BUS_W-1:0]               lane_c,
    output logic [BUS_W-1:0]               voted_out,
    output logic                           err_corr,
    output logic                           err_uncorr,
    output logic [1:0]                     fault_id,
    input  logic                           err_clear,
    input  logic                           resync_start,
    output logic                           core_hold,
    output logic [$clog2(STATE_WORDS)-1:0] state_idx,
    input  logic [STATE_W-1:0]             st_out_a,
    input  logic [STATE_W-1:0]             st_out_b,
    input  logic [STATE_W-1:0]             st_out_c,
    input  logic [2:0]                     st_out_vld,
    output logic [STATE_W-1:0]             st_in_data,
    output logic                           st_in_we,
    output logic                           resync_fail
);
    flag_t      flag_d, flag_q;
    logic       corr_hit, uncorr_hit;
    logic [1:0] odd_id;
    logic       busy, done_ok;

    tmr_maj #(.W(BUS_W)) u_bus_vote (
        .a (lane_a),
        .b (lane_b),
        .c (lane_c),
        .y (voted_out)
    );

    tmr_classify #(.W(BUS_W)) u_classify (
        .a          (lane_a),
        .b          (lane_b),
        .c          (lane_c),
        .en         (!busy),
        .pend       (flag_q.corr),
        .pend_id    (flag_q.fid),
        .corr_hit   (corr_hit),
        .uncorr_hit (uncorr_hit),
        .odd_id     (odd_id)
    );

    tmr_resync_seq #(
        .STATE_W (STATE_W),
        .WORDS   (STATE_WORDS),
        .BUDGET  (BUDGET)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (resync_start),
        .clear   (err_clear),
        .st_a    (st_out_a),
        .st_b    (st_out_b),
        .st_c    (st_out_c),
        .st_vld  (st_out_vld),
        .busy    (busy),
        .idx     (state_idx),
        .wr_en   (st_in_we),
        .wr_data (st_in_data),
        .done_ok (done_ok),
        .fail    (resync_fail)
    );

    always_comb begin
        flag_d = flag_q;
        if (err_clear || done_ok) begin
            flag_d = '{corr: 1'b0, uncorr: 1'b0, fid: NO_FAULT};
        end else begin
            if (corr_hit) begin
                flag_d.corr = 1'b1;
                flag_d.fid  = odd_id;
            end
            if (uncorr_hit) begin
                flag_d.uncorr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '{corr: 1'b0, uncorr: 1'b0, fid: NO_FAULT};
        end else begin
            flag_q <= flag_d;
        end
    end

    assign err_corr   = flag_q.corr;
    assign err_uncorr = flag_q.uncorr;
    assign fault_id   = flag_q.fid;
    assign core_hold  = busy;
endmodule

// File: rtl/tmr_lockstep_guard_chk.sv
module tmr_lockstep_guard_chk #(
    parameter int BUS_W  = 32,
    parameter int BUDGET = 2500
) (
    input logic             clk,
    input logic             rst_n,
    input logic [BUS_W-1:0] lane_a,
    input logic [BUS_W-1:0] lane_b,
    input logic [BUS_W-1:0] voted_out,
    input logic             err_corr,
    input logic             err_uncorr,
    input logic [1:0]       fault_id,
    input logic             err_clear,
    input logic             core_hold,
    input logic             st_in_we,
    input logic             resync_fail
);
    localparam int CNT_W = $clog2(BUDGET + 2);

    logic [CNT_W-1:0] hold_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt_q <= '0;
        end else if (core_hold) begin
            hold_cnt_q <= hold_cnt_q + 1'b1;
        end else begin
            hold_cnt_q <= '0;
        end
    end

    assert_pair_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_a == lane_b) |-> (voted_out == lane_a));

    assert_fid_named_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err_corr |-> (fault_id != 2'd3));

    assert_fid_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_corr && !err_clear && !core_hold) |=> (err_corr && fault_id == $past(fault_id)));

    assert_uncorr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_uncorr && !err_clear && !core_hold) |=> err_uncorr);

    assert_write_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_in_we |-> core_hold);

    assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(core_hold) && !resync_fail) |-> (!err_corr && !err_uncorr && fault_id == 2'd3));

    assert_hold_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        core_hold |-> (hold_cnt_q < CNT_W'(BUDGET)));

    assert_fail_on_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resync_fail) |-> $fell(core_hold));

    assert_quiet_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (core_hold && !err_uncorr) |=> !err_uncorr);
endmodule

bind tmr_lockstep_guard tmr_lockstep_guard_chk #(
    .BUS_W  (BUS_W),
    .BUDGET (BUDGET)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lane_a      (lane_a),
    .lane_b      (lane_b),
    .voted_out   (voted_out),
    .err_corr    (err_corr),
    .err_uncorr  (err_uncorr),
    .fault_id    (fault_id),
    .err_clear   (err_clear),
    .core_hold   (core_hold),
    .st_in_we    (st_in_we),
    .resync_fail (resync_fail)
);

// File: tb/tmr_lockstep_guard_bench.sv
`timescale 1ns/1ps
module tmr_lockstep_guard_bench;
    localparam int BW = 8;
    localparam int SW = 8;
    localparam int NW = 6;
    localparam int BG = 20;
    localparam int IW = $clog2(NW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [BW-1:0] lane_a = '0, lane_b = '0, lane_c = '0;
    logic [BW-1:0] voted_out;
    logic          err_corr, err_uncorr, core_hold, st_in_we, resync_fail;
    logic [1:0]    fault_id;
    logic          err_clear = 1'b0, resync_start = 1'b0;
    logic [IW-1:0] state_idx;
    logic [SW-1:0] st_out_a, st_out_b, st_out_c, st_in_data;
    logic [2:0]    st_out_vld = 3'b111;

    logic [SW-1:0] s0 [NW];
    logic [SW-1:0] s1 [NW];
    logic [SW-1:0] s2 [NW];
    logic [SW-1:0] wr_dat [16];
    int            wr_ix [16];
    int            wr_n = 0;

    int  nchk = 0, nerr = 0, cyc = 0;
    bit  exp_corr = 0, exp_uncorr = 0;
    logic [1:0] exp_fid = 2'd3;

    always #2 clk = ~clk;

    assign st_out_a = s0[state_idx];
    assign st_out_b = s1[state_idx];
    assign st_out_c = s2[state_idx];

    tmr_lockstep_guard #(
        .BUS_W(BW), .STATE_W(SW), .STATE_WORDS(NW), .BUDGET(BG)
    ) u_tmr_lockstep_guard (
        .clk(clk), .rst_n(rst_n),
        .lane_a(lane_a), .lane_b(lane_b), .lane_c(lane_c),
        .voted_out(voted_out), .err_corr(err_corr), .err_uncorr(err_uncorr),
        .fault_id(fault_id), .err_clear(err_clear), .resync_start(resync_start),
        .core_hold(core_hold), .state_idx(state_idx),
        .st_out_a(st_out_a), .st_out_b(st_out_b), .st_out_c(st_out_c),
        .st_out_vld(st_out_vld), .st_in_data(st_in_data), .st_in_we(st_in_we),
        .resync_fail(resync_fail)
    );

    always @(negedge clk) begin
        if (st_in_we && wr_n < 16) begin
            wr_dat[wr_n] = st_in_data;
            wr_ix[wr_n]  = int'(state_idx);
            wr_n++;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [BW-1:0] ref_vote(input logic [BW-1:0] x, y, z);
        logic [BW-1:0] r;
        for (int i = 0; i < BW; i++) begin
            int ones;
            ones = int'(x[i]) + int'(y[i]) + int'(z[i]);
            r[i] = (ones >= 2);
        end
        return r;
    endfunction

    function automatic logic [BW-1:0] nz_mask();
        logic [BW-1:0] m;
        m = BW'($urandom);
        if (m == '0) m = 1;
        return m;
    endfunction

    task automatic model_update(input logic [BW-1:0] x, y, z, input bit clr);
        logic [BW-1:0] ln [3];
        ln[0] = x; ln[1] = y; ln[2] = z;
        if (clr) begin
            exp_corr = 0; exp_uncorr = 0; exp_fid = 2'd3;
        end else if (exp_corr) begin
            logic [BW-1:0] p, q;
            p = (exp_fid == 2'd0) ? ln[1] : ln[0];
            q = (exp_fid == 2'd2) ? ln[1] : ln[2];
            if (p != q) exp_uncorr = 1;
        end else if (x != y && x != z && y != z) begin
            exp_uncorr = 1;
        end else begin
            for (int k = 0; k < 3; k++) begin
                if (ln[(k + 1) % 3] == ln[(k + 2) % 3] && ln[k] != ln[(k + 1) % 3]) begin
                    exp_corr = 1;
                    exp_fid  = 2'(k);
                end
            end
        end
    endtask

    task automatic check_flags(input string tag);
        check(err_corr == exp_corr, {tag, " err_corr (R2)"}, int'(err_corr), int'(exp_corr));
        check(err_uncorr == exp_uncorr, {tag, " err_uncorr (R3)"}, int'(err_uncorr), int'(exp_uncorr));
        check(fault_id == exp_fid, {tag, " fault_id (R4)"}, int'(fault_id), int'(exp_fid));
    endtask

    task automatic step(input logic [BW-1:0] x, y, z, input bit clr, input string tag);
        @(negedge clk);
        check_flags(tag);
        lane_a = x; lane_b = y; lane_c = z; err_clear = clr;
        #1;
        check(voted_out == ref_vote(x, y, z), {tag, " voted_out R1"},
              int'(voted_out), int'(ref_vote(x, y, z)));
        model_update(x, y, z, clr);
    endtask

    task automatic settle(input string tag);
        @(negedge clk);
        check_flags(tag);
        err_clear = 1'b0;
    endtask

    task automatic run_resync(input int stall, output int held);
        int cnt;
        cnt = 0;
        wr_n = 0;
        @(negedge clk);
        st_out_vld = (stall > 0) ? 3'b011 : 3'b111;
        resync_start = 1'b1;
        forever begin
            @(negedge clk);
            if (cnt == 0) check(core_hold == 1'b1, "hold after start R6", int'(core_hold), 1);
            if (!core_hold || cnt > 200) break;
            cnt++;
            st_out_vld   = (cnt > stall) ? 3'b111 : 3'b011;
            resync_start = (cnt == 4);
            lane_a = 8'h11; lane_b = 8'h22; lane_c = 8'h44;
        end
        resync_start = 1'b0;
        lane_a = 8'h5a; lane_b = 8'h5a; lane_c = 8'h5a;
        st_out_vld = 3'b111;
        held = cnt;
    endtask

    task automatic check_restore(input string tag);
        check(wr_n == NW, {tag, " write count R7"}, wr_n, NW);
        for (int w = 0; w < NW && w < wr_n; w++) begin
            check(wr_ix[w] == w, {tag, " write order R7"}, wr_ix[w], w);
            check(wr_dat[w] == ref_vote(s0[w], s1[w], s2[w]), {tag, " restored word R7"},
                  int'(wr_dat[w]), int'(ref_vote(s0[w], s1[w], s2[w])));
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                nerr++;
                $display("FAIL watchdog R6 actual=%0d expected=%0d", cyc, 20000);
                $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
                $finish;
            end
        end
    end

    initial begin
        int held;
        void'($urandom(32'd4242));
        for (int w = 0; w < NW; w++) begin
            s0[w] = SW'($urandom);
            s1[w] = s0[w];
            s2[w] = s0[w];
        end
        s1[1] = s1[1] ^ 8'h0f;
        s1[3] = s1[3] ^ 8'hf0;
        s2[4] = s2[4] ^ 8'h81;
        s0[5] = 8'h0f; s1[5] = 8'h33; s2[5] = 8'h55;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(err_corr == 0 && err_uncorr == 0, "reset flags R5", int'({err_corr, err_uncorr}), 0);
        check(fault_id == 2'd3, "reset fault_id R2", int'(fault_id), 3);
        check(core_hold == 0 && st_in_we == 0 && resync_fail == 0, "reset seq R6",
              int'({core_hold, st_in_we, resync_fail}), 0);

        step(8'h3c, 8'h3c, 8'h3c, 0, "equal R1");
        step(8'h3c, 8'h3d, 8'h3c, 0, "lane b odd R2");
        step(8'h3c, 8'hff, 8'h3c, 0, "pending lane ignored R4");
        step(8'h00, 8'h3c, 8'h3c, 0, "other pair split R4");
        step(8'h00, 8'h00, 8'h00, 1, "clear R5");
        step(8'h01, 8'h02, 8'h04, 1, "clear wins R5");
        step(8'h01, 8'h02, 8'h04, 0, "three way R3");
        step(8'h07, 8'h07, 8'h07, 1, "clear R5");
        step(8'h07, 8'h07, 8'h17, 0, "lane c odd R2");
        settle("settle R2");

        for (int n = 0; n < 300; n++) begin
            logic [BW-1:0] base, m1, m2, x, y, z;
            int kind, ln;
            base = BW'($urandom);
            kind = $urandom % 8;
            x = base; y = base; z = base;
            if (kind == 4 || kind == 5) begin
                ln = $urandom % 3;
                m1 = nz_mask();
                if (ln == 0) x = base ^ m1;
                else if (ln == 1) y = base ^ m1;
                else z = base ^ m1;
            end else if (kind == 6) begin
                m1 = nz_mask();
                m2 = nz_mask();
                if (m2 == m1) m2 = m1 ^ 8'h80;
                if (m2 == '0) m2 = 8'h01;
                y = base ^ m1; z = base ^ m2;
            end
            step(x, y, z, kind == 7, "random R2");
        end
        settle("random end R3");

        step(8'h5a, 8'h5a, 8'h5a, 1, "pre resync clear R5");
        step(8'h5a, 8'h5b, 8'h5a, 0, "pre resync fault R2");
        settle("pre resync R2");
        run_resync(0, held);
        check(held == 2 * NW, "hold length R7", held, 2 * NW);
        check(err_corr == 0 && err_uncorr == 0, "flags cleared by resync R8",
              int'({err_corr, err_uncorr}), 0);
        check(fault_id == 2'd3, "fault_id after resync R8", int'(fault_id), 3);
        check(resync_fail == 0, "no fail R8", int'(resync_fail), 0);
        check_restore("run1");
        exp_corr = 0; exp_uncorr = 0; exp_fid = 2'd3;
        step(8'h5a, 8'h5a, 8'h5a, 0, "after resync R10");
        settle("quiet hold R10");

        run_resync(3, held);
        check(held == 2 * NW + 3, "stalled push length R6", held, 2 * NW + 3);
        check_restore("run2 R6");

        step(8'h01, 8'h02, 8'h04, 0, "pre timeout R3");
        settle("pre timeout R3");
        run_resync(1000, held);
        check(held == BG, "abort after budget R9", held, BG);
        check(resync_fail == 1, "fail set R9", int'(resync_fail), 1);
        check(err_uncorr == 1, "flags kept on abort R9", int'(err_uncorr), 1);
        check(wr_n == 0, "no restore on abort R9", wr_n, 0);
        repeat (3) @(negedge clk);
        check(resync_fail == 1, "fail sticky R9", int'(resync_fail), 1);
        step(8'h5a, 8'h5a, 8'h5a, 1, "clear after abort R5");
        settle("clear after abort R5");
        check(resync_fail == 0, "clear drops fail R5", int'(resync_fail), 0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule